// File: doc/BRIEF.md
# Pixel-Paced Bus Target Ready Generator

This block is the small amount of target-side logic that lets an image sensor with a tri-state data output answer burst reads from a bus initiator. The block assumes it is the only target on the bus. It does not decode addresses: every transaction the initiator starts is treated as a read of the sensor. The block claims the transaction with an active-low device-select once the address cycle has passed, and it keeps that claim until the initiator ends the burst.

The data beats are paced by the sensor's pixel clock. That clock runs at one quarter of the bus clock and is generated elsewhere. The pixel clock is brought into the bus-clock domain through a register chain. A falling pixel edge arms a ready pulse one bus cycle after the edge is seen, and a rising edge removes the pulse immediately. The result is a one-cycle active-low target-ready for every pixel, placed while the sensor's data is stable.

While the sensor's line-valid is low, target-ready is held high, so the initiator waits with no limit on how long. A sensor output-enable is raised only during the data phase while line-valid is high.

Top module: `sensor_ready_glue`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `devsel_n` and `trdy_n` are 1 and `sensor_oe` is 0.
- R2: The cycle in which `frame_n` is first seen low is an address cycle that the block ignores: `devsel_n` stays 1 after that edge and goes to 0 after the following edge, whatever the bus carries.
- R3: `devsel_n` stays 0 for the whole data phase and returns to 1 after the first rising edge at which both `frame_n` and `irdy_n` are 1. `trdy_n` is never 0 while `devsel_n` is 1.
- R4: With the default two-stage synchronizer, `trdy_n` goes to 0 after the rising edge that follows the second consecutive edge sampling `pix_clk` low. This requires that the data phase and `line_valid` = 1 hold across that window.
- R5: `trdy_n` returns to 1 in the same cycle in which the synchronized pixel clock is seen high, with no extra register delay. At the 4:1 ratio, each pixel gives a ready pulse exactly one bus cycle wide.
- R6: A burst of N beats completes with exactly N ready pulses, one per pixel, for every phase of the pixel clock relative to the start of the burst.
- R7: While `line_valid` is 0, `trdy_n` is 1 and `devsel_n` stays 0. The transaction waits until `line_valid` returns.
- R8: `sensor_oe` is 1 only during the data phase while `line_valid` is 1.
- R9: After a captured beat (`trdy_n` and `irdy_n` both 0 at a rising edge), `trdy_n` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Initiator transaction-in-progress, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| pix_clk | input | 1 | Sensor pixel clock, one quarter of the bus clock, asynchronous |
| line_valid | input | 1 | Sensor line-valid, active high |
| devsel_n | output | 1 | Device-select claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| sensor_oe | output | 1 | Enable for the sensor's tri-state data drivers |

## Verification
The hardest situation to reach from the ports is a ready pulse that lines up with a particular point of the burst. Examples are a pixel whose falling edge arrives in the address cycle, or a falling edge that arrives in the same cycle as the initiator's last beat. The stimulus reaches these cases by sweeping the pixel-clock phase offset over all four positions, crossed with burst lengths of one to five beats. It also runs each burst once with `line_valid` held low for several pixels before it is raised. The expected `trdy_n` of each cycle is derived from the sampled `pix_clk` history and from a phase model of the bus handshake.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

    // Number of register stages used to bring the pixel clock into the bus domain
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Bus transaction phase as seen by the target
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_t;

    // Synchronized pixel clock with its edge strobes
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pix_edge_t;

    // A beat transfers when both ready lines are low at a clock edge
    function automatic logic beat_taken(logic trdy_low_n, logic irdy_low_n);
        return (!trdy_low_n) && (!irdy_low_n);
    endfunction

    // Transaction end: both initiator lines released
    function automatic logic burst_over(logic frame_low_n, logic irdy_low_n);
        return frame_low_n && irdy_low_n;
    endfunction

endpackage

// File: rtl/sgl_pix_sync.sv
module sgl_pix_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain;

    generate
        if (N == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[N-2:0], d};
            end
        end
    endgenerate

    assign q = chain[N-1];
endmodule

// File: rtl/sgl_edge_detect.sv
module sgl_edge_detect
    import sgl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level_s,
    output pix_edge_t edges
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b0;
        else     level_d <= level_s;
    end

    always_comb begin
        edges.level = level_s;
        edges.rise  = level_s && !level_d;
        edges.fall  = !level_s && level_d;
    end
endmodule

// File: rtl/sgl_bus_phase.sv
module sgl_bus_phase
    import sgl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_n,
    input  logic       irdy_n,
    output bus_phase_t phase
);
    bus_phase_t phase_nx;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: if (!frame_n) phase_nx = PH_ADDR;
            PH_ADDR: phase_nx = PH_DATA;
            PH_DATA: if (burst_over(frame_n, irdy_n)) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/sgl_ready_pacer.sv
module sgl_ready_pacer
    import sgl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pix_edge_t edges,
    input  logic      in_data,
    input  logic      line_valid,
    input  logic      irdy_n,
    output logic      trdy_n
);
    logic armed;
    logic beat;

    // Ready is low only while armed, the pixel is still low, and the line is live
    assign trdy_n = !(armed && !edges.level && in_data && line_valid);
    assign beat   = beat_taken(trdy_n, irdy_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (!in_data || edges.rise || beat) begin
            armed <= 1'b0;
        end else if (edges.fall && line_valid) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/sensor_ready_glue.sv
module sensor_ready_glue
    import sgl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic pix_clk,
    input  logic line_valid,
    output logic devsel_n,
    output logic trdy_n,
    output logic sensor_oe
);
    logic       pix_s;
    pix_edge_t  pix_e;
    bus_phase_t phase;
    logic       in_data;

    sgl_pix_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pix_clk),
        .q   (pix_s)
    );

    sgl_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_s (pix_s),
        .edges   (pix_e)
    );

    sgl_bus_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .phase   (phase)
    );

    assign in_data = (phase == PH_DATA);

    sgl_ready_pacer u_pacer (
        .clk        (clk),
        .rst        (rst),
        .edges      (pix_e),
        .in_data    (in_data),
        .line_valid (line_valid),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n)
    );

    assign devsel_n  = !in_data;
    assign sensor_oe = in_data && line_valid;
endmodule

// File: rtl/sgl_glue_checker.sv
module sgl_glue_checker (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic irdy_n,
    input logic line_valid,
    input logic devsel_n,
    input logic trdy_n,
    input logic sensor_oe
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (devsel_n && trdy_n && !sensor_oe));

    assert_addr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(frame_n) && devsel_n) |=> devsel_n);

    assert_claim_first_R3: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !devsel_n);

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && frame_n && irdy_n) |=> devsel_n);

    assert_wait_on_line_R7: assert property (@(posedge clk) disable iff (rst)
        !line_valid |-> trdy_n);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        sensor_oe |-> (line_valid && !devsel_n));

    assert_one_beat_R9: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n) |=> trdy_n);
endmodule

bind sensor_ready_glue sgl_glue_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .line_valid (line_valid),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .sensor_oe  (sensor_oe)
);

// File: tb/sensor_ready_glue_test.sv
`timescale 1ns/1ps
module sensor_ready_glue_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1;
    logic irdy_n = 1'b1;
    logic pix_clk = 1'b0;
    logic line_valid = 1'b0;
    logic devsel_n, trdy_n, sensor_oe;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int pix_off = 0;
    int beats = 0;
    int lv_off_pulses = 0;
    int wide_pulses = 0;
    bit pend = 1'b0;
    bit prev_low = 1'b0;
    bit [3:0] hist = '0;
    int st = 0;       // 0 idle, 1 address, 2 data
    int st_prev = 0;

    sensor_ready_glue uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .pix_clk(pix_clk), .line_valid(line_valid),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .sensor_oe(sensor_oe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Pixel clock: 4 bus cycles per pixel, 2 high then 2 low, shifted by pix_off
    always @(negedge clk) pix_clk <= (((cyc + pix_off) % 4) < 2);

    // Reference model and per-cycle checks
    always @(posedge clk) begin
        bit exp_low;
        cyc++;
        hist = {hist[2:0], pix_clk};
        if (pend) beats++;
        st_prev = st;
        if (rst) st = 0;
        else if (st == 0 && !frame_n) st = 1;
        else if (st == 1) st = 2;
        else if (st == 2 && frame_n && irdy_n) st = 0;
        if (cyc > 100000) begin
            chk(1'b0, "R6 watchdog", cyc, 100000);
            finish_run();
        end
        #1;
        if (!rst) begin
            // R4 R5: low only after falling edge seen through two stages plus one delay
            exp_low = hist[3] && !hist[2] && !hist[1] && st_prev == 2 && st == 2 && line_valid;
            chk(trdy_n == !exp_low, "R4 R5 trdy_n", trdy_n, !exp_low);
            chk(devsel_n == (st != 2), "R2 R3 devsel_n", devsel_n, st != 2);
            chk(sensor_oe == (st == 2 && line_valid), "R8 sensor_oe", sensor_oe, st == 2 && line_valid);
            if (!line_valid && !trdy_n) lv_off_pulses++;
            if (!trdy_n && prev_low) wide_pulses++;
            prev_low = !trdy_n;
            pend = !trdy_n && !irdy_n;
        end else begin
            pend = 1'b0;
            prev_low = 1'b0;
        end
    end

    task automatic burst(int len, int lv_delay);
        int waited;
        waited = 0;
        beats = 0;
        @(negedge clk);
        frame_n = 1'b0;
        line_valid = (lv_delay == 0);
        @(negedge clk);
        irdy_n = 1'b0;
        if (len == 1) frame_n = 1'b1;
        while (beats < len) begin
            @(negedge clk);
            waited++;
            if (!line_valid && waited >= lv_delay) line_valid = 1'b1;
            if (beats == len - 1) frame_n = 1'b1;
        end
        irdy_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(beats == len, "R6 beat count", beats, len);
        chk(devsel_n == 1'b1, "R3 released", devsel_n, 1);
        line_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(devsel_n && trdy_n && !sensor_oe, "R1 in reset", {devsel_n, trdy_n, sensor_oe}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        chk(devsel_n && trdy_n && !sensor_oe, "R1 after reset", {devsel_n, trdy_n, sensor_oe}, 3'b110);
        // Idle with a live line: no claim and no ready
        line_valid = 1'b1;
        repeat (12) @(negedge clk);
        chk(devsel_n == 1'b1 && trdy_n == 1'b1, "R2 idle no claim", {devsel_n, trdy_n}, 2'b11);
        line_valid = 1'b0;
        for (int off = 0; off < 4; off++) begin
            pix_off = off;
            repeat (6) @(negedge clk);
            for (int len = 1; len <= 5; len++) begin
                burst(len, 0);
                burst(len, 9);
            end
        end
        chk(lv_off_pulses == 0, "R7 ready while line idle", lv_off_pulses, 0);
        chk(wide_pulses == 0, "R9 R5 pulse width", wide_pulses, 0);
        finish_run();
    end
endmodule